// File: doc/BRIEF.md
# Broadcast-Form FIR Filter with Split Multipliers

This block is a three-tap FIR filter built in transposed form. Each accepted input sample goes to every coefficient multiplier in the same cycle, so there is no input delay line. The running sums travel through registers placed between the adders. Each multiplier is cut in two by a pipeline register. The first half forms two partial products, one from the low half of the coefficient and one from the high half. The second half merges them, and that merge shares a clock cycle with one adder of the accumulation chain. This limits the critical path to about half a multiply plus one add.

Samples arrive on a stream qualified by `valid_i`, and results leave on a stream qualified by `valid_o`. The filter history advances only on valid input cycles, so idle cycles can appear anywhere in the stream without changing the result. The coefficients come in on a port. They are expected to change only while the pipeline holds no live history.

Top module: `bcast_fir`

## Requirements
- R1: For each accepted sample x(n), the output equals a·x(n) + b·x(n−1) + c·x(n−2), computed exactly in signed two's complement. Here a is `coef_i[0]`, b is `coef_i[1]` and c is `coef_i[2]`, and x(n−1) and x(n−2) are the previous accepted samples.
- R2: Every cycle in which `valid_i` is high yields exactly one cycle with `valid_o` high, two clock cycles later. `y_o` carries that sample's result in the same cycle.
- R3: A cycle in which `valid_i` is low yields `valid_o` low two cycles later, and it does not move the sample history.
- R4: While `rst_ni` is low, `valid_o` and `y_o` are zero. After reset, samples not yet received count as zero in R1.
- R5: `y_o` keeps its last value in every cycle in which `valid_o` is low.
- R6: Inputs and coefficients at the extremes of the 16-bit signed range, including −32768 times −32768, give exact results. There is no wrap in any product or in the 34-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| x_i | input | 16 | Signed input sample |
| coef_i | input | 3x16 | Signed coefficients; element 0 multiplies the newest sample |
| valid_o | output | 1 | Output sample qualifier |
| y_o | output | 34 | Signed filter result |

## Verification
The product-range and exact-product assertions assume only that inputs stay within their declared signed widths. They hold for any coefficient values. The output-value checks assume more: the coefficients must stay constant while partial sums built from them are still in the delay chain. For this reason the stimulus pushes two zero samples and two idle cycles through the filter before each coefficient change. This leaves every delay register at zero. The latency and bubble properties assume that `valid_i` is meaningful only outside reset, so the stimulus holds every input low while `rst_ni` is asserted.

// File: rtl/bfir_pkg.sv
package bfir_pkg;
  // headroom so a sum of n full products cannot wrap
  function automatic int guard_bits(input int n_taps);
    return $clog2(n_taps + 1);
  endfunction
endpackage

// File: rtl/bfir_split_mult.sv
module bfir_split_mult #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W  = A_W + B_W,
  localparam int LO_W = B_W / 2,
  localparam int HI_W = B_W - LO_W,
  localparam int LP_W = A_W + LO_W + 1,
  localparam int HP_W = A_W + HI_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [A_W-1:0] a_i,
  input  logic signed [B_W-1:0] b_i,
  output logic signed [P_W-1:0] prod_o
);
  logic signed [LP_W-1:0] a_lo_x, b_lo_x, pp_lo_d, pp_lo_q;
  logic signed [HP_W-1:0] a_hi_x, b_hi_x, pp_hi_d, pp_hi_q;

  // stage 1: low coefficient half is unsigned, high half carries the sign
  assign a_lo_x  = {{(LO_W+1){a_i[A_W-1]}}, a_i};
  assign b_lo_x  = {{A_W{1'b0}}, 1'b0, b_i[LO_W-1:0]};
  assign a_hi_x  = {{HI_W{a_i[A_W-1]}}, a_i};
  assign b_hi_x  = {{A_W{b_i[B_W-1]}}, b_i[B_W-1:LO_W]};
  assign pp_lo_d = a_lo_x * b_lo_x;
  assign pp_hi_d = a_hi_x * b_hi_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_lo_q <= '0;
      pp_hi_q <= '0;
    end else begin
      pp_lo_q <= pp_lo_d;
      pp_hi_q <= pp_hi_d;
    end
  end

  // stage 2: merge, shares its cycle with one chain adder
  assign prod_o = ({{LO_W{pp_hi_q[HP_W-1]}}, pp_hi_q} <<< LO_W)
                + {{(P_W-LP_W){pp_lo_q[LP_W-1]}}, pp_lo_q};

  // checker-only: marks that the cut register holds a post-reset product
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  localparam logic signed [P_W-1:0] P_LIM = P_W'(1) <<< (P_W - 2);

  AST_MULT_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> prod_o == P_W'($past(a_i)) * P_W'($past(b_i))); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (prod_o <= P_LIM) && (prod_o >= -P_LIM)); // R6
endmodule

// File: rtl/bfir_sum_chain.sv
module bfir_sum_chain #(
  parameter int N_TAPS = 3,
  parameter int P_W    = 32,
  parameter int ACC_W  = 34
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic [N_TAPS-1:0][P_W-1:0]     prod_i,
  output logic signed [ACC_W-1:0]        y_o
);
  logic signed [ACC_W-1:0] part_q [N_TAPS-1];
  logic signed [ACC_W-1:0] nxt    [N_TAPS-1];
  logic signed [ACC_W-1:0] y_q;

  // part_q[k] carries the sum for taps k+1 .. N_TAPS-1
  for (genvar k = 0; k < N_TAPS - 1; k++) begin : g_node
    if (k == N_TAPS - 2) begin : g_far
      assign nxt[k] = ACC_W'($signed(prod_i[k+1]));
    end else begin : g_mid
      assign nxt[k] = ACC_W'($signed(prod_i[k+1])) + part_q[k+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_TAPS - 1; k++) part_q[k] <= '0;
      y_q <= '0;
    end else if (en_i) begin
      for (int k = 0; k < N_TAPS - 1; k++) part_q[k] <= nxt[k];
      y_q <= ACC_W'($signed(prod_i[0])) + part_q[0];
    end
  end

  assign y_o = y_q;
endmodule

// File: rtl/bcast_fir.sv
module bcast_fir
  import bfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int N_TAPS = 3,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + guard_bits(N_TAPS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic signed [DATA_W-1:0]          x_i,
  input  logic [N_TAPS-1:0][COEF_W-1:0]     coef_i,
  output logic                              valid_o,
  output logic signed [ACC_W-1:0]           y_o
);
  logic [N_TAPS-1:0][PROD_W-1:0] prod;
  logic v_cut_q, v_out_q;

  // same sample fans out to every multiplier
  for (genvar t = 0; t < N_TAPS; t++) begin : g_mult
    bfir_split_mult #(.A_W(DATA_W), .B_W(COEF_W)) i_mult (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (x_i),
      .b_i    ($signed(coef_i[t])),
      .prod_o (prod[t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_cut_q <= 1'b0;
      v_out_q <= 1'b0;
    end else begin
      v_cut_q <= valid_i;
      v_out_q <= v_cut_q;
    end
  end

  bfir_sum_chain #(.N_TAPS(N_TAPS), .P_W(PROD_W), .ACC_W(ACC_W)) i_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (v_cut_q),
    .prod_i (prod),
    .y_o    (y_o)
  );

  assign valid_o = v_out_q;

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o); // R2
  AST_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o)); // R5
endmodule

// File: tb/test_bcast_fir.sv
module test_bcast_fir;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic signed [15:0] xin = '0;
  logic [2:0][15:0] coef = '0;
  logic vout;
  logic signed [33:0] yout;

  int tests = 0;
  int fails = 0;

  longint h1 = 0, h2 = 0, ca = 0, cb = 0, cc = 0;
  bit ev1 = 0, ev2 = 0;
  longint ey1 = 0, ey2 = 0, last_y = 0;

  always #2.5 clk = ~clk;

  bcast_fir i_bcast_fir (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .x_i(xin),
    .coef_i(coef), .valid_o(vout), .y_o(yout)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_coef(input longint a, input longint b, input longint c);
    ca = a; cb = b; cc = c;
    coef = {16'(c), 16'(b), 16'(a)};
  endtask

  // one cycle: check result of the sample driven two steps back, then drive
  task automatic step(input bit v, input longint x);
    longint e;
    @(negedge clk);
    if (ev2) begin
      chk(vout == 1'b1, "R2 valid_o", longint'(vout), 1);
      chk(longint'(yout) == ey2, "R1/R6 y_o", longint'(yout), ey2);
      last_y = ey2;
    end else begin
      chk(vout == 1'b0, "R3 valid_o", longint'(vout), 0);
      chk(longint'(yout) == last_y, "R5 y_o hold", longint'(yout), last_y);
    end
    vin = v;
    xin = 16'(x);
    e = 0;
    if (v) begin
      e = ca * x + cb * h1 + cc * h2;
      h2 = h1;
      h1 = x;
    end
    ev2 = ev1; ey2 = ey1;
    ev1 = v;   ey1 = e;
  endtask

  // push zeros so no partial sum built with old coefficients survives
  task automatic flush();
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    h1 = 0; h2 = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint cv[6];
    longint xv[8];
    logic [15:0] lf;
    cv = '{-32768, -1, 0, 1, 12345, 32767};
    xv = '{-32768, 32767, -1, 1, 0, -20000, 777, 32767};

    set_coef(3, -5, 7);
    repeat (4) @(negedge clk);
    chk(vout == 1'b0, "R4 valid_o in reset", longint'(vout), 0);
    chk(yout == '0, "R4 y_o in reset", longint'(yout), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // first samples see zero history (R4)
    step(1, 100); step(1, -200); step(1, 300); step(0, 0); step(1, 5);
    flush();

    // sweep coefficient triples over signed extremes with bubbles (R1 R3 R5 R6)
    for (int ia = 0; ia < 6; ia++)
      for (int ib = 0; ib < 6; ib++)
        for (int ic = 0; ic < 6; ic++) begin
          set_coef(cv[ia], cv[ib], cv[ic]);
          for (int i = 0; i < 12; i++)
            step((i % 5) != 3, xv[(i + ia + ib) % 8]);
          flush();
        end

    // worst-case magnitude: all operands -32768 (R6)
    set_coef(-32768, -32768, -32768);
    for (int i = 0; i < 5; i++) step(1, -32768);
    flush();

    // pseudo-random data and valid pattern (R1 R2 R3)
    set_coef(-12000, 31000, -7);
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3] | lf[7], longint'($signed(lf)));
    end
    flush();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule